// File: doc/BRIEF.md
# Two-Wire Memory Slave Bus Front End

This block is the bit-level slave side of a two-wire serial memory device. A fast system clock oversamples the bus clock and data lines. From the sampled lines the block finds START and STOP conditions and shifts bytes in and out, most significant bit first. It checks the first byte of each transfer against a fixed device prefix and three strap inputs. It acknowledges by pulling the data line low in the ninth clock slot. The data line is never driven high: the only drive output is a pull-down enable.

Toward the memory core the block offers three interfaces:
- A selection pulse that reports the transfer direction.
- A valid/ready stream of received write bytes.
- A valid/ready stream of bytes to transmit, with a pulse that reports the master's acknowledge after each transmitted byte.

A busy input from the core turns the address acknowledge into silence. The master can therefore poll until internal programming completes.

Back-pressure follows from the fact that the block cannot stretch the bus clock:
- Receive stream: `rx_valid` stays high until `rx_ready` is seen. If the core has not taken a byte by the time the next byte completes, the new byte replaces the old one.
- Transmit stream: `tx_ready` is high only while the block waits for the next byte, which is during the ninth clock slot before a read byte. A byte must be offered within that slot. If none is offered, the block sends 0xFF, which leaves the line released.

Top module: `tw_slave_frontend`

## Requirements
- R1: After reset the data line is released (`sda_pull`=0), and `rx_valid`, `sel_valid`, `mack_valid`, `bus_stop` and `tx_ready` are all 0.
- R2: `sda_pull` changes only after a falling edge of the bus clock, while the clock is low. Incoming bits are taken on rising edges.
- R3: The first byte after START is the address: bits 7..4 must be 1010, bits 3..1 must equal `strap_addr[2:0]`, and bit 0 is 1 for read and 0 for write. On a match the block pulls the line low for the whole ninth clock and pulses `sel_valid`, with `sel_read` giving bit 0.
- R4: With `strap_off`=1, any value of address bits 3..1 is accepted.
- R5: On an address mismatch the block gives no acknowledge. Until the next START it ignores the bus: no acknowledges, no received bytes and no selection pulse.
- R6: While `core_busy`=1, a matching address is not acknowledged, no selection pulse is given, and the bus is ignored until the next START.
- R7: In a write, each data byte is acknowledged and presented on `rx_data` with `rx_valid`. `rx_valid` holds until `rx_ready`. A byte that completes while the previous one is still held replaces it.
- R8: In a read, the byte taken on a `tx_valid`/`tx_ready` handshake is sent MSB first, as pull = inverted bit. If no byte was offered, 0xFF is sent.
- R9: In the ninth slot of a read byte the block releases the line and pulses `mack_valid`, with `mack_more`=1 when the master held the line low. On acknowledge the next byte follows. On no-acknowledge the block stays released until the next START.
- R10: A START at any bit position aborts the byte in progress and returns the block to the address phase.
- R11: A STOP at any bit position releases the line, pulses `bus_stop`, and leaves the block idle until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 = pull the data line low; 0 = release |
| strap_addr | input | 3 | Strap value compared with address bits 3..1 |
| strap_off | input | 1 | 1 = skip the strap comparison |
| core_busy | input | 1 | Core is programming; address is not acknowledged |
| sel_valid | output | 1 | One-cycle pulse: address acknowledged |
| sel_read | output | 1 | Direction of the acknowledged address, 1 = read |
| rx_valid | output | 1 | Received write byte is available |
| rx_ready | input | 1 | Core accepts the received byte |
| rx_data | output | 8 | Received write byte |
| tx_valid | input | 1 | Core offers a byte to transmit |
| tx_ready | output | 1 | Block is waiting for the next transmit byte |
| tx_data | input | 8 | Byte to transmit |
| mack_valid | output | 1 | One-cycle pulse: master acknowledge slot sampled |
| mack_more | output | 1 | 1 = master acknowledged and wants another byte |
| bus_stop | output | 1 | One-cycle pulse on a STOP condition |

## Verification
Every registered result of this block, whether `sda_pull`, a selection, receive or master-acknowledge pulse, or a change of `tx_ready`, appears on the third system clock after the bench moves a bus line. Two synchronizer stages and one edge register lie on that path. The bench therefore holds each bus level for 16 clocks. Its behavioural model gives the expected pull value from the moment it lowers the clock, and it compares `sda_pull` with that value on every clock from the fifth clock after a change until the next change. Pulse outputs are counted as they occur and checked once the bit slot that produces them has ended.

// File: rtl/tw_slave_pkg.sv
package tw_slave_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until START
    ST_RECV,   // shifting in address or write data
    ST_ACK,    // holding the acknowledge through the ninth clock
    ST_SEND,   // shifting out a read byte
    ST_MACK,   // sampling the master acknowledge
    ST_LOAD    // master acknowledged, next byte goes out on the falling edge
  } fe_state_t;

  // Device address check: prefix always, strap bits unless disabled.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [2:0]        strap,
                                    input logic              off);
    return (b[7:4] == DEV_PREFIX) && (off || (b[3:1] == strap));
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One flop chain per line; idle bus level is high, so reset to 1.
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/tw_cond.sv
module tw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_prv, sda_prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prv <= 1'b1;
      sda_prv <= 1'b1;
    end else begin
      scl_prv <= scl_lvl;
      sda_prv <= sda_lvl;
    end
  end

  logic scl_steady_high;
  assign scl_steady_high = scl_lvl & scl_prv;

  assign scl_rise = scl_lvl & ~scl_prv;
  assign scl_fall = ~scl_lvl & scl_prv;
  assign start_c  = scl_steady_high & sda_prv & ~sda_lvl;
  assign stop_c   = scl_steady_high & ~sda_prv & sda_lvl;

endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic [2:0]        strap_addr,
  input  logic              strap_off,
  input  logic              core_busy,
  output logic              pull,
  output logic              sel_valid,
  output logic              sel_read,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              mack_valid,
  output logic              mack_more,
  output logic              bus_stop
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  fe_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              is_addr;
  logic              rd;
  logic [BYTE_W-1:0] tx_hold;
  logic              tx_have;
  logic [BYTE_W-1:0] next_out;

  // Byte to start shifting out: the offered one, or all-ones (line released).
  assign next_out = tx_have ? tx_hold : '1;

  // No capture in the falling-edge cycle, so a byte cannot be lost between capture and load.
  assign tx_ready = !tx_have && !scl_fall && !start_c && !stop_c &&
                    ((state == ST_ACK && rd) || state == ST_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      is_addr    <= 1'b0;
      rd         <= 1'b0;
      pull       <= 1'b0;
      sel_valid  <= 1'b0;
      sel_read   <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      tx_hold    <= '0;
      tx_have    <= 1'b0;
      mack_valid <= 1'b0;
      mack_more  <= 1'b0;
      bus_stop   <= 1'b0;
    end else begin
      sel_valid  <= 1'b0;
      mack_valid <= 1'b0;
      bus_stop   <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (tx_ready && tx_valid) begin
        tx_hold <= tx_data;
        tx_have <= 1'b1;
      end

      if (stop_c) begin
        state    <= ST_IDLE;
        pull     <= 1'b0;
        bus_stop <= 1'b1;
        tx_have  <= 1'b0;
      end else if (start_c) begin
        state   <= ST_RECV;
        is_addr <= 1'b1;
        cnt     <= '0;
        pull    <= 1'b0;
        tx_have <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_RECV: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end
            if (scl_fall && cnt == FULL) begin
              if (is_addr) begin
                if (addr_hit(sh, strap_addr, strap_off) && !core_busy) begin
                  pull      <= 1'b1;
                  rd        <= sh[0];
                  sel_valid <= 1'b1;
                  sel_read  <= sh[0];
                  state     <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                rx_data  <= sh;
                rx_valid <= 1'b1;
                pull     <= 1'b1;
                state    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              if (rd) begin
                sh      <= next_out;
                pull    <= ~next_out[BYTE_W-1];
                cnt     <= CNT_W'(1);
                tx_have <= 1'b0;
                state   <= ST_SEND;
              end else begin
                pull  <= 1'b0;
                cnt   <= '0;
                state <= ST_RECV;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                pull  <= 1'b0;
                state <= ST_MACK;
              end else begin
                pull <= ~sh[BYTE_W-2];
                sh   <= {sh[BYTE_W-2:0], 1'b1};
                cnt  <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_valid <= 1'b1;
              mack_more  <= ~sda_lvl;
              state      <= sda_lvl ? ST_IDLE : ST_LOAD;
            end
          end
          ST_LOAD: begin
            if (scl_fall) begin
              sh      <= next_out;
              pull    <= ~next_out[BYTE_W-1];
              cnt     <= CNT_W'(1);
              tx_have <= 1'b0;
              state   <= ST_SEND;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: the pull-down only moves while the synchronized bus clock is low
  p_pull_low_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> !scl_lvl);

  // R3: every selection pulse comes with the acknowledge pull
  p_sel_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> pull);

  // R6: a busy core silences the address slot
  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV && is_addr && scl_fall && cnt == FULL && core_busy && !start_c && !stop_c)
    |=> (!pull && !sel_valid && state == ST_IDLE));

  // R7: a received byte stays offered until taken
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R9: the master acknowledge slot is never driven by the slave
  p_mack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mack_valid |-> !pull);

  // R11: STOP releases the line and parks the block
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!pull && state == ST_IDLE && bus_stop));

endmodule

// File: rtl/tw_slave_frontend.sv
module tw_slave_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic [2:0] strap_addr,
  input  logic       strap_off,
  input  logic       core_busy,
  output logic       sel_valid,
  output logic       sel_read,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       mack_valid,
  output logic       mack_more,
  output logic       bus_stop
);

  logic [1:0] lines_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  tw_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (lines_s[1]),
    .sda_lvl  (lines_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  tw_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (lines_s[1]),
    .sda_lvl    (lines_s[0]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_c    (start_c),
    .stop_c     (stop_c),
    .strap_addr (strap_addr),
    .strap_off  (strap_off),
    .core_busy  (core_busy),
    .pull       (sda_pull),
    .sel_valid  (sel_valid),
    .sel_read   (sel_read),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .mack_valid (mack_valid),
    .mack_more  (mack_more),
    .bus_stop   (bus_stop)
  );

endmodule

// File: tb/tw_slave_frontend_test.sv
module tw_slave_frontend_test;

  localparam int H = 16;   // clocks per bus phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_line;
  logic [2:0] strap = 3'b101;
  logic strap_off = 1'b0, busy = 1'b0;
  logic sel_valid, sel_read, rx_valid, rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic mack_valid, mack_more, bus_stop;

  assign sda_line = m_sda & ~sda_pull;

  tw_slave_frontend uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull(sda_pull),
    .strap_addr(strap), .strap_off(strap_off), .core_busy(busy),
    .sel_valid(sel_valid), .sel_read(sel_read),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mack_valid(mack_valid), .mack_more(mack_more), .bus_stop(bus_stop)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0, chg = 0;
  logic exp_pull = 1'b0;
  bit ph_cmp = 0, ph_bad = 0;
  logic ph_act, ph_exp;
  int n_sel = 0, n_mack = 0, n_stop = 0;
  logic last_rd = 1'b0, last_more = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (sel_valid) begin n_sel++; last_rd = sel_read; end
      if (mack_valid) begin n_mack++; last_more = mack_more; end
      if (bus_stop) n_stop++;
      if (rx_valid && rx_ready) rx_q.push_back(rx_data);
      if (tx_valid && tx_ready && tx_q.size() != 0) void'(tx_q.pop_front());
    end
  end

  always @(negedge clk) begin
    tx_valid <= (tx_q.size() != 0);
    tx_data  <= (tx_q.size() != 0) ? tx_q[0] : 8'h00;
  end

  // Model comparison of the pull-down on every settled clock (R2, R8)
  always @(negedge clk) begin
    if (rst_n && (cyc - chg) >= 5) begin
      ph_cmp = 1;
      if (sda_pull !== exp_pull && !ph_bad) begin
        ph_bad = 1; ph_act = sda_pull; ph_exp = exp_pull;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic c, input logic d, input logic ep);
    if (ph_cmp) check(!ph_bad, "R2 sda_pull vs model", int'(ph_act), int'(ph_exp));
    ph_cmp = 0; ph_bad = 0;
    @(negedge clk);
    m_scl = c; m_sda = d; exp_pull = ep; chg = cyc;
    repeat (H) @(negedge clk);
  endtask

  task automatic do_start();
    drive(0, 1, 0); drive(1, 1, 0); drive(1, 0, 0); drive(0, 0, 0);
  endtask

  task automatic do_stop();
    drive(0, 0, 0); drive(1, 0, 0); drive(1, 1, 0);
  endtask

  task automatic wbit(input logic b, input logic ep_after);
    drive(0, b, exp_pull); drive(1, b, exp_pull); drive(0, b, ep_after);
  endtask

  task automatic wbyte(input logic [7:0] v, input logic ack, input logic nxt, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) wbit(v[i], (i == 0) ? ack : 1'b0);
    drive(0, 1, exp_pull); drive(1, 1, exp_pull);
    got = sda_line;
    check(got == ~ack, tag, int'(got), int'(~ack));
    drive(0, 1, nxt);
  endtask

  task automatic rbyte(input logic [7:0] v, input logic more, input logic nxt, input string tag);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      drive(0, 1, exp_pull); drive(1, 1, exp_pull);
      got[i] = sda_line;
      drive(0, 1, (i > 0) ? ~v[i-1] : 1'b0);
    end
    check(got == v, tag, int'(got), int'(v));
    drive(0, ~more, 0); drive(1, ~more, 0); drive(0, ~more, nxt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int nrx, ns;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sda_pull == 0 && rx_valid == 0 && sel_valid == 0 && mack_valid == 0
          && bus_stop == 0 && tx_ready == 0, "R1 reset outputs", int'(sda_pull), 0);

    // R3 write address with matching strap, R7 data bytes
    do_start();
    wbyte(8'b1010_101_0, 1, 0, "R3 write address ack");
    check(n_sel == 1 && last_rd == 0, "R3 sel pulse write", n_sel, 1);
    wbyte(8'h5A, 1, 0, "R7 data ack 5A");
    wbyte(8'hC3, 1, 0, "R7 data ack C3");
    check(rx_q.size() == 2 && rx_q[0] == 8'h5A && rx_q[1] == 8'hC3, "R7 rx bytes",
          (rx_q.size() == 2) ? int'(rx_q[1]) : rx_q.size(), 8'hC3);
    do_stop();
    check(n_stop == 1, "R11 stop pulse", n_stop, 1);

    // R5 strap mismatch: silent, later bytes ignored
    nrx = rx_q.size(); ns = n_sel;
    do_start();
    wbyte(8'b1010_011_0, 0, 0, "R5 mismatch no ack");
    wbyte(8'h11, 0, 0, "R5 ignored byte no ack");
    check(rx_q.size() == nrx && n_sel == ns && !rx_valid, "R5 no rx no sel", rx_q.size(), nrx);

    // R3 wrong prefix via repeated start
    do_start();
    wbyte(8'b1011_101_0, 0, 0, "R3 wrong prefix no ack");
    do_stop();

    // R4 strap comparison disabled
    strap_off = 1'b1;
    do_start();
    wbyte(8'b1010_011_0, 1, 0, "R4 strap off ack");
    do_stop();
    strap_off = 1'b0;

    // R6 busy core
    busy = 1'b1; ns = n_sel;
    do_start();
    wbyte(8'b1010_101_0, 0, 0, "R6 busy no ack");
    wbyte(8'h22, 0, 0, "R6 busy ignores data");
    check(n_sel == ns, "R6 no sel while busy", n_sel, ns);
    do_stop();
    busy = 1'b0;

    // R8/R9 sequential read: ack then nack
    tx_q.push_back(8'h96); tx_q.push_back(8'h3C);
    do_start();
    wbyte(8'b1010_101_1, 1, 0, "R3 read address ack");   // 0x96 MSB=1 -> released
    check(last_rd == 1, "R3 sel_read", int'(last_rd), 1);
    rbyte(8'h96, 1, 1, "R8 read byte 96");                // 0x3C MSB=0 -> pulled
    check(last_more == 1, "R9 master ack seen", int'(last_more), 1);
    rbyte(8'h3C, 0, 0, "R8 read byte 3C");
    check(last_more == 0 && n_mack == 2, "R9 master nack seen", n_mack, 2);
    check(sda_pull == 0, "R9 released after nack", int'(sda_pull), 0);
    do_stop();

    // R8 nothing offered -> all ones
    do_start();
    wbyte(8'b1010_101_1, 1, 0, "R8 read address ack");
    rbyte(8'hFF, 0, 0, "R8 empty source FF");
    do_stop();

    // R10 repeated START in mid-byte
    nrx = rx_q.size();
    tx_q.push_back(8'h81);
    do_start();
    wbyte(8'b1010_101_0, 1, 0, "R10 write address ack");
    wbit(1, 0); wbit(0, 0); wbit(1, 0); wbit(1, 0);
    do_start();
    wbyte(8'b1010_101_1, 1, 0, "R10 address after restart");
    check(rx_q.size() == nrx, "R10 partial byte dropped", rx_q.size(), nrx);
    rbyte(8'h81, 0, 0, "R10 read after restart");
    do_stop();

    // R7 hold and overwrite without ready
    rx_ready = 1'b0; nrx = rx_q.size();
    do_start();
    wbyte(8'b1010_101_0, 1, 0, "R7 address ack");
    wbyte(8'h11, 1, 0, "R7 byte 11 ack");
    check(rx_valid == 1 && rx_data == 8'h11, "R7 held byte", int'(rx_data), 8'h11);
    wbyte(8'h22, 1, 0, "R7 byte 22 ack");
    check(rx_valid == 1 && rx_data == 8'h22, "R7 overwrite", int'(rx_data), 8'h22);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rx_q.size() == nrx + 1 && rx_q[rx_q.size()-1] == 8'h22 && !rx_valid,
          "R7 accepted once", rx_q.size(), nrx + 1);

    // R11 STOP in mid-byte, later byte ignored
    ns = n_stop;
    wbit(0, 0); wbit(1, 0); wbit(1, 0);
    do_stop();
    check(n_stop == ns + 1 && sda_pull == 0, "R11 mid-byte stop", n_stop, ns + 1);
    drive(0, 1, 0);
    wbyte(8'b1010_101_0, 0, 0, "R11 idle after stop");

    drive(0, 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule